// File: doc/BRIEF.md
# UART Receive Data Buffer with Error-Tagged FIFO

This block sits behind a UART deserializer and holds the characters it finishes. Every completed frame arrives on a one-cycle strobe, together with its parity, framing and overrun status and two attributes: whether the frame carries 7 data bits, and whether it was shifted MSB first. The block has two modes. In the first it keeps a single 8-bit holding register. In the second it queues up to 16 halfword entries, and each entry keeps its own parity and framing flags beside the data. Software can drain the queue with byte reads, which discard the flags, or with halfword reads, which return them.

Two interrupt pulses serve the receive path. The end-of-reception pulse marks every load in single mode. In queue mode it fires when the fill level reaches a programmable trigger. The idle-timeout pulse fires in queue mode when data is waiting and no new start bit has appeared within a programmable number of bit times. Clearing the power-enable input returns every part of the block to its reset contents.

Top module: `rxq_buffer`

## Requirements
- R1: In single mode (`fifo_mode`=0), a loaded byte appears on `rd_byte_data` and as {8'h00, byte} on `rd_half_data` from the cycle after the load edge. Read strobes leave it unchanged.
- R2: A frame is stored only on a cycle where `frm_done`=1, `rx_en`=1 and `pwr_en`=1. With `rx_en`=0 the visible value and the entry count are unchanged.
- R3: In single mode `irq_end` is high for exactly one cycle, in the cycle after each load edge.
- R4: In queue mode each entry reads as bits 7:0 data, bit 8 parity error, bit 9 framing error, bits 15:10 zero. Entries leave in arrival order, and at most 16 are held.
- R5: When `frm_len7`=1, an LSB-first frame is stored with bit 7 forced to 0. An MSB-first frame (`frm_msb_first`=1) is stored with bit 0 forced to 0.
- R6: A frame with `frm_ovr`=1 is not stored in either mode and raises no `irq_end`.
- R7: After reset, or after any cycle with `pwr_en`=0, the visible value is 8'hFF in single mode and 16'h00FF in queue mode. A read of an empty queue returns 16'h00FF and does not move the read position.
- R8: In queue mode a pulse on `rd_byte` or `rd_half` removes the head entry. `rd_byte_data` carries only the data bits of the head entry.
- R9: A load into a full queue without a simultaneous read is dropped and sets `ovf_flag`. The flag stays set until reset or `pwr_en`=0.
- R10: In queue mode `irq_end` pulses for one cycle when a load without a simultaneous read raises the count to `trig_lvl`+1. So `trig_lvl`=0 means 1 entry and `trig_lvl`=15 means 16 entries.
- R11: In queue mode with a non-empty queue, `irq_tmo` pulses for one cycle on the (`wait_lim`+1)-th `bit_tick` since the last `start_det` or load. It fires at most once until the next restart.
- R12: A load and a read in the same cycle in queue mode both take effect and leave the count unchanged, even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Power enable; low clears the block |
| rx_en | input | 1 | Receive enable |
| fifo_mode | input | 1 | 0 single register, 1 queue |
| trig_lvl | input | 4 | Queue fill trigger minus one |
| wait_lim | input | 5 | Idle timeout in bit ticks minus one |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| start_det | input | 1 | Start bit detected |
| frm_done | input | 1 | Frame complete strobe |
| frm_data | input | 8 | Frame data from the shift register |
| frm_perr | input | 1 | Parity error of the frame |
| frm_ferr | input | 1 | Framing error of the frame |
| frm_ovr | input | 1 | Overrun on the frame |
| frm_len7 | input | 1 | Frame has 7 data bits |
| frm_msb_first | input | 1 | Frame shifted MSB first |
| rd_byte | input | 1 | Byte read strobe (pops in queue mode) |
| rd_half | input | 1 | Halfword read strobe (pops in queue mode) |
| rd_byte_data | output | 8 | Visible data byte |
| rd_half_data | output | 16 | Visible halfword with flags |
| irq_end | output | 1 | Reception-end pulse |
| irq_tmo | output | 1 | Reception-timeout pulse |
| ovf_flag | output | 1 | Sticky queue overflow |

## Verification
A frame load and a queue read can fall in the same cycle. The bench provokes this by raising `frm_done` and `rd_half` together on one edge, both with a partly filled queue and with a full one. It judges the result through the scoreboard. The head it compared before the edge must be gone, the new frame must come out last, the entry count must neither grow past 16 nor shrink, and no overflow or trigger pulse may appear. A second coincidence, a start bit arriving part way through an idle count, is judged by the timeout firing only after a full fresh window.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int BYTE_W = 8;
   localparam int HALF_W = 16;

   typedef struct packed {
      logic              ferr;
      logic              perr;
      logic [BYTE_W-1:0] data;
   } rxq_entry_t;

   localparam int ENT_W = $bits(rxq_entry_t);

   function automatic logic [HALF_W-1:0] entry_to_half(input rxq_entry_t e);
      return {{(HALF_W-ENT_W){1'b0}}, e};
   endfunction
endpackage

// File: rtl/rxq_justify.sv
module rxq_justify
   import rxq_pkg::*;
(
   input  logic [BYTE_W-1:0] din,
   input  logic              short_frame,
   input  logic              msb_first,
   output logic [BYTE_W-1:0] dout
);
   always_comb begin
      dout = din;
      if (short_frame) begin
         if (msb_first) dout[0]        = 1'b0;
         else           dout[BYTE_W-1] = 1'b0;
      end
   end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int OCC_W = AW + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  rxq_entry_t       wdata,
   input  logic             rd,
   output rxq_entry_t       head,
   output logic [OCC_W-1:0] occ
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("rxq_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   rxq_entry_t      slot_q [DEPTH];
   logic [AW-1:0]   wptr, rptr;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (wr && wptr == AW'(i)) slot_q[i] <= wdata;
         end
      end
   endgenerate

   assign head = slot_q[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         occ  <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
         occ  <= '0;
      end else begin
         if (wr) wptr <= wptr + 1'b1;
         if (rd) rptr <= rptr + 1'b1;
         case ({wr, rd})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
   parameter int CNT_W = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             restart,
   input  logic             tick,
   input  logic             enable,
   input  logic [CNT_W-1:0] limit,
   output logic             fire
);
   logic [CNT_W-1:0] cnt;
   logic             armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
         fire  <= 1'b0;
      end else if (clr) begin
         cnt   <= '0;
         armed <= 1'b0;
         fire  <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (restart) begin
            cnt   <= '0;
            armed <= 1'b1;
         end else if (tick && armed && enable) begin
            if (cnt == limit) begin
               fire  <= 1'b1;
               armed <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
   import rxq_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int TRIG_W = 4,
   parameter int TMO_W  = 5,
   localparam int OCC_W = $clog2(DEPTH) + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_en,
   input  logic              rx_en,
   input  logic              fifo_mode,
   input  logic [TRIG_W-1:0] trig_lvl,
   input  logic [TMO_W-1:0]  wait_lim,
   input  logic              bit_tick,
   input  logic              start_det,
   input  logic              frm_done,
   input  logic [BYTE_W-1:0] frm_data,
   input  logic              frm_perr,
   input  logic              frm_ferr,
   input  logic              frm_ovr,
   input  logic              frm_len7,
   input  logic              frm_msb_first,
   input  logic              rd_byte,
   input  logic              rd_half,
   output logic [BYTE_W-1:0] rd_byte_data,
   output logic [HALF_W-1:0] rd_half_data,
   output logic              irq_end,
   output logic              irq_tmo,
   output logic              ovf_flag
);
   generate
      if ((1 << TRIG_W) != DEPTH) begin : g_bad_trig
         $error("rxq_buffer: trigger field must span 1..DEPTH");
      end
      if (TMO_W < 1) begin : g_bad_tmo
         $error("rxq_buffer: TMO_W must be positive");
      end
   endgenerate

   localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;

   logic [BYTE_W-1:0] just_data;
   logic [BYTE_W-1:0] hold_q;
   logic [OCC_W-1:0]  occ;
   logic [OCC_W-1:0]  trig_target;
   rxq_entry_t        new_ent, head_ent;
   logic              clr, load_ok, q_full, q_empty, pop, q_wr, q_drop, hit_trig;

   rxq_justify u_just (
      .din         (frm_data),
      .short_frame (frm_len7),
      .msb_first   (frm_msb_first),
      .dout        (just_data)
   );

   assign clr     = !pwr_en;
   assign load_ok = pwr_en && rx_en && frm_done && !frm_ovr;
   assign q_full  = (occ == OCC_W'(DEPTH));
   assign q_empty = (occ == '0);
   assign pop     = pwr_en && fifo_mode && (rd_byte || rd_half) && !q_empty;
   assign q_wr    = load_ok && fifo_mode && (!q_full || pop);
   assign q_drop  = load_ok && fifo_mode && q_full && !pop;

   assign new_ent.ferr = frm_ferr;
   assign new_ent.perr = frm_perr;
   assign new_ent.data = just_data;

   rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .wr    (q_wr),
      .wdata (new_ent),
      .rd    (pop),
      .head  (head_ent),
      .occ   (occ)
   );

   rxq_idle_timer #(.CNT_W(TMO_W)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .restart (start_det || q_wr),
      .tick    (bit_tick),
      .enable  (fifo_mode && !q_empty),
      .limit   (wait_lim),
      .fire    (irq_tmo)
   );

   assign trig_target = OCC_W'(trig_lvl) + 1'b1;
   assign hit_trig    = q_wr && !pop && ((occ + 1'b1) == trig_target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= IDLE_BYTE;
         irq_end  <= 1'b0;
         ovf_flag <= 1'b0;
      end else if (clr) begin
         hold_q   <= IDLE_BYTE;
         irq_end  <= 1'b0;
         ovf_flag <= 1'b0;
      end else begin
         if (load_ok && !fifo_mode) hold_q <= just_data;
         irq_end <= (load_ok && !fifo_mode) || hit_trig;
         if (q_drop) ovf_flag <= 1'b1;
      end
   end

   always_comb begin
      if (!fifo_mode)   rd_half_data = {{(HALF_W-BYTE_W){1'b0}}, hold_q};
      else if (q_empty) rd_half_data = {{(HALF_W-BYTE_W){1'b0}}, IDLE_BYTE};
      else              rd_half_data = entry_to_half(head_ent);
   end

   assign rd_byte_data = rd_half_data[BYTE_W-1:0];
endmodule

// File: rtl/rxq_buffer_chk.sv
module rxq_buffer_chk #(
   parameter int DEPTH = 16,
   localparam int OCC_W = $clog2(DEPTH) + 1
)(
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_en,
   input logic             rx_en,
   input logic             fifo_mode,
   input logic             frm_done,
   input logic             frm_ovr,
   input logic             rd_byte,
   input logic             rd_half,
   input logic [15:0]      rd_half_data,
   input logic             irq_end,
   input logic             irq_tmo,
   input logic             ovf_flag,
   input logic [OCC_W-1:0] occ
);
   AST_SINGLE_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && !fifo_mode && rx_en && frm_done && !frm_ovr) |=> irq_end); // R3

   AST_NO_LOAD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && fifo_mode && !rx_en && !rd_byte && !rd_half) |=> $stable(occ)); // R2

   AST_OVR_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && fifo_mode && frm_done && frm_ovr && !rd_byte && !rd_half) |=> $stable(occ)); // R6

   AST_EMPTY_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_mode && occ == '0) |-> (rd_half_data == 16'h00FF)); // R7

   AST_PWR_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |=> (occ == '0 && !ovf_flag && !irq_end)); // R7

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && pwr_en) |=> ovf_flag); // R9

   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCC_W'(DEPTH)); // R4

   AST_LOAD_POP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && fifo_mode && rx_en && frm_done && !frm_ovr && (rd_byte || rd_half) && occ != '0)
      |=> $stable(occ)); // R12

   AST_TMO_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tmo |=> !irq_tmo); // R11
endmodule

bind rxq_buffer rxq_buffer_chk #(.DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pwr_en       (pwr_en),
   .rx_en        (rx_en),
   .fifo_mode    (fifo_mode),
   .frm_done     (frm_done),
   .frm_ovr      (frm_ovr),
   .rd_byte      (rd_byte),
   .rd_half      (rd_half),
   .rd_half_data (rd_half_data),
   .irq_end      (irq_end),
   .irq_tmo      (irq_tmo),
   .ovf_flag     (ovf_flag),
   .occ          (occ)
);

// File: tb/sim_rxq_buffer.sv
module sim_rxq_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_en = 1'b0, rx_en = 1'b0, fifo_mode = 1'b0;
   logic [3:0]  trig_lvl = 4'd0;
   logic [4:0]  wait_lim = 5'd0;
   logic        bit_tick = 1'b0, start_det = 1'b0;
   logic        frm_done = 1'b0, frm_perr = 1'b0, frm_ferr = 1'b0, frm_ovr = 1'b0;
   logic        frm_len7 = 1'b0, frm_msb_first = 1'b0;
   logic [7:0]  frm_data = 8'h00;
   logic        rd_byte = 1'b0, rd_half = 1'b0;
   logic [7:0]  rd_byte_data;
   logic [15:0] rd_half_data;
   logic        irq_end, irq_tmo, ovf_flag;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [15:0] exp_q [$];

   always #2.5 clk = ~clk;

   rxq_buffer u0 (.*);

   task automatic cmp(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic drive_frame(input logic [7:0] d, input logic pe, input logic fe,
                              input logic ov, input logic l7, input logic msb);
      frm_data = d; frm_perr = pe; frm_ferr = fe; frm_ovr = ov;
      frm_len7 = l7; frm_msb_first = msb; frm_done = 1'b1;
      step();
      frm_done = 1'b0; frm_perr = 1'b0; frm_ferr = 1'b0; frm_ovr = 1'b0;
      frm_len7 = 1'b0; frm_msb_first = 1'b0;
   endtask

   // driver: queue-mode load, pushes the expected entry into the scoreboard
   task automatic q_load(input logic [7:0] d, input logic pe, input logic fe, input string req);
      bit exp_irq;
      exp_irq = (exp_q.size() < 16) && (exp_q.size() + 1 == int'(trig_lvl) + 1);
      if (exp_q.size() < 16) exp_q.push_back({6'b0, fe, pe, d});
      drive_frame(d, pe, fe, 1'b0, 1'b0, 1'b0);
      cmp(req, "irq_end after load", {15'b0, irq_end}, {15'b0, exp_irq});
   endtask

   // monitor: compares head against scoreboard, then pops
   task automatic q_read(input bit half, input string req);
      logic [15:0] exp;
      exp = (exp_q.size() == 0) ? 16'h00FF : exp_q.pop_front();
      if (half) cmp(req, "halfword head", rd_half_data, exp);
      else      cmp(req, "byte head", {8'h00, rd_byte_data}, {8'h00, exp[7:0]});
      rd_half = half; rd_byte = !half;
      step();
      rd_half = 1'b0; rd_byte = 1'b0;
   endtask

   task automatic tick_check(input logic exp, input string what);
      bit_tick = 1'b1;
      step();
      bit_tick = 1'b0;
      cmp("R11", what, {15'b0, irq_tmo}, {15'b0, exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] head_v;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // reset state
      cmp("R7", "reset byte", {8'h00, rd_byte_data}, 16'h00FF);
      cmp("R7", "reset irq/ovf", {13'b0, irq_end, irq_tmo, ovf_flag}, 16'h0);
      fifo_mode = 1'b1; #1;
      cmp("R7", "reset queue view", rd_half_data, 16'h00FF);
      fifo_mode = 1'b0;
      pwr_en = 1'b1; rx_en = 1'b1;
      step();

      // single mode
      drive_frame(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      cmp("R1", "single byte", {8'h00, rd_byte_data}, 16'h005A);
      cmp("R1", "single half", rd_half_data, 16'h005A);
      cmp("R3", "end pulse high", {15'b0, irq_end}, 16'h1);
      step();
      cmp("R3", "end pulse one cycle", {15'b0, irq_end}, 16'h0);
      rd_byte = 1'b1; rd_half = 1'b1; step(); rd_byte = 1'b0; rd_half = 1'b0;
      cmp("R1", "read keeps value", {8'h00, rd_byte_data}, 16'h005A);
      rx_en = 1'b0;
      drive_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      cmp("R2", "disabled load ignored", {8'h00, rd_byte_data}, 16'h005A);
      cmp("R2", "no pulse when disabled", {15'b0, irq_end}, 16'h0);
      rx_en = 1'b1;
      drive_frame(8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      cmp("R6", "overrun single ignored", {8'h00, rd_byte_data}, 16'h005A);
      cmp("R6", "overrun no pulse", {15'b0, irq_end}, 16'h0);
      drive_frame(8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      cmp("R5", "7-bit lsb first", {8'h00, rd_byte_data}, 16'h007F);
      drive_frame(8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      cmp("R5", "7-bit msb first", {8'h00, rd_byte_data}, 16'h00FE);
      pwr_en = 1'b0; step(); pwr_en = 1'b1;
      cmp("R7", "power off single", {8'h00, rd_byte_data}, 16'h00FF);

      // queue mode, trigger at 3 entries
      fifo_mode = 1'b1; trig_lvl = 4'd2;
      step();
      q_load(8'hA1, 1'b1, 1'b0, "R10");
      q_load(8'hA2, 1'b0, 1'b1, "R10");
      q_load(8'hA3, 1'b1, 1'b1, "R10");
      q_load(8'hA4, 1'b0, 0, "R10");
      drive_frame(8'h33, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      cmp("R6", "overrun queue no pulse", {15'b0, irq_end}, 16'h0);
      q_read(1'b1, "R4");
      q_read(1'b0, "R8");
      q_read(1'b1, "R4");
      q_read(1'b1, "R4");
      q_read(1'b1, "R7");
      cmp("R7", "still empty after empty read", rd_half_data, 16'h00FF);
      q_load(8'hB0, 1'b0, 1'b0, "R7");
      q_read(1'b1, "R7");

      // fill to full, trigger at 16
      trig_lvl = 4'd15;
      for (int i = 0; i < 16; i++) q_load(8'hC0 + 8'(i), 1'(i % 2), 1'b0, "R10");
      cmp("R9", "no overflow at 16", {15'b0, ovf_flag}, 16'h0);
      q_load(8'hEE, 1'b0, 1'b0, "R9");
      cmp("R9", "overflow set", {15'b0, ovf_flag}, 16'h1);
      // simultaneous load and pop while full
      head_v = exp_q.pop_front();
      cmp("R12", "head before load+pop", rd_half_data, head_v);
      exp_q.push_back({6'b0, 1'b1, 1'b0, 8'h5D});
      frm_data = 8'h5D; frm_ferr = 1'b1; frm_done = 1'b1; rd_half = 1'b1;
      step();
      frm_done = 1'b0; frm_ferr = 1'b0; rd_half = 1'b0;
      cmp("R12", "no trigger on load+pop", {15'b0, irq_end}, 16'h0);
      // partly filled simultaneous case
      for (int i = 0; i < 10; i++) q_read(1'b1, "R12");
      head_v = exp_q.pop_front();
      cmp("R12", "head before partial load+pop", rd_half_data, head_v);
      exp_q.push_back({6'b0, 1'b0, 1'b1, 8'h6E});
      frm_data = 8'h6E; frm_perr = 1'b1; frm_done = 1'b1; rd_byte = 1'b1;
      step();
      frm_done = 1'b0; frm_perr = 1'b0; rd_byte = 1'b0;
      while (exp_q.size() > 0) q_read(1'b1, "R12");
      cmp("R12", "drained", rd_half_data, 16'h00FF);
      cmp("R9", "overflow still sticky", {15'b0, ovf_flag}, 16'h1);

      // idle timeout, window of 4 ticks
      wait_lim = 5'd3; trig_lvl = 4'd0;
      q_load(8'h71, 1'b0, 1'b0, "R10");
      tick_check(1'b0, "tick 1");
      tick_check(1'b0, "tick 2");
      tick_check(1'b0, "tick 3");
      tick_check(1'b1, "tick 4 fires");
      tick_check(1'b0, "tick 5 once only");
      tick_check(1'b0, "tick 6 once only");
      start_det = 1'b1; step(); start_det = 1'b0;
      tick_check(1'b0, "restart tick 1");
      tick_check(1'b0, "restart tick 2");
      start_det = 1'b1; step(); start_det = 1'b0;
      tick_check(1'b0, "second restart tick 1");
      tick_check(1'b0, "second restart tick 2");
      tick_check(1'b0, "second restart tick 3");
      tick_check(1'b1, "second restart tick 4 fires");
      q_read(1'b1, "R4");
      start_det = 1'b1; step(); start_det = 1'b0;
      for (int i = 0; i < 6; i++) tick_check(1'b0, "empty queue no timeout");

      // power off in queue mode
      q_load(8'h81, 1'b0, 1'b0, "R10");
      pwr_en = 1'b0; step(); pwr_en = 1'b1;
      exp_q.delete();
      cmp("R7", "power off queue view", rd_half_data, 16'h00FF);
      cmp("R9", "power off clears overflow", {15'b0, ovf_flag}, 16'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule